// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block is a watchdog counter clocked by the oscillator. Software must service it with a service strobe before a chosen period runs out. If it does not, the block raises a reset request for one clock and keeps a sticky flag that names the watchdog as the cause of the last reset.

The period is 2^S − 2^O oscillator cycles. S is one of two exponents, short or long, and O is a small offset exponent. With the default parameters the two periods are 2^13 − 16 and 2^18 − 16 cycles. The counter loads 2^O on every restart and expires when its selected low bits are all ones. This produces the odd period exactly, without a wide comparator.

A configuration port accepts one write after each reset and ignores any later write. That write carries a rate-select bit and a disable bit. Reset clears both bits, so the watchdog comes up active with the long period. The synchronous power-on reset clears everything. The synchronous system reset clears everything except the cause flag.

Top module: `wdog_timer`

## Requirements
- R1: With the rate bit set to 1, a request appears exactly 2^SHORT_EXP − 2^OFF_EXP cycles after a restart. The request output is high in the cycle that follows the N-th rising edge after the edge that sampled the restart.
- R2: With the rate bit at 0, the same measure gives 2^LONG_EXP − 2^OFF_EXP cycles.
- R3: Either reset clears the rate and disable bits. After a reset the long period applies, measured from the last edge that sampled reset.
- R4: While the disable bit is 1, no request is ever raised. A service strobe during that time also produces no request.
- R5: A request lasts exactly one cycle. The count then restarts by itself, so with no service the requests repeat every period.
- R6: The cause flag is high from the cycle after a request.
- R7: Only the power-on reset clears the cause flag. A system reset leaves it set.
- R8: Only the first configuration write after a reset is taken. Later writes change neither the period nor the enable, and they do not restart the count.
- R9: A service strobe restarts the count. The next request comes exactly one period after the edge that sampled the strobe.
- R10: A strobe sampled on the edge where the count would expire wins. No request is raised at that edge.
- R11: An accepted configuration write restarts the count, and the new period is measured from the edge that sampled the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_rst | input | 1 | Synchronous power-on reset, active high; clears all state |
| sys_rst | input | 1 | Synchronous system reset, active high; keeps the cause flag |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_short | input | 1 | Rate select: 1 short period, 0 long period |
| cfg_halt | input | 1 | 1 disables the watchdog |
| kick | input | 1 | Service strobe |
| wdt_rst_req | output | 1 | One-cycle reset request |
| wdt_cause | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
The count itself is not visible at the ports. An off-by-one in the preload, the terminal decode or the restart path therefore shows up only as a request one cycle early or late, a full period after the stimulus. The bench measures every interval to the exact cycle, so a single-cycle error is detected in the first period it affects. A stuck lock bit or a lost disable shows at the ports within one period, as a period that is wrong or as a request that should not occur. A cause flag that is not sticky shows in the cycle after the next system reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Configuration held by the write-once register.
    typedef struct packed {
        logic short_rate;  // 1: short period, 0: long period
        logic halt;        // 1: watchdog disabled
    } wdog_cfg_t;

    localparam wdog_cfg_t WDOG_CFG_RESET = '{short_rate: 1'b0, halt: 1'b0};

    // Action the counter takes on the next edge.
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_RESTART = 2'd1,
        ACT_EXPIRE  = 2'd2,
        ACT_STEP    = 2'd3
    } wdog_act_t;

    // Action priority: reset, then disable, then restart, then terminal, then step.
    function automatic wdog_act_t wdog_pick(input logic halt, input logic restart,
                                            input logic at_term);
        if (halt)         return ACT_HOLD;
        else if (restart) return ACT_RESTART;
        else if (at_term) return ACT_EXPIRE;
        else              return ACT_STEP;
    endfunction

endpackage

// File: rtl/wdog_cfg_lock.sv
module wdog_cfg_lock
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  wdog_cfg_t wr_data,
    output wdog_cfg_t cfg,
    output logic      cfg_load
);
    logic locked;

    assign cfg_load = wr && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= WDOG_CFG_RESET;
            locked <= 1'b0;
        end else if (cfg_load) begin
            cfg    <= wr_data;
            locked <= 1'b1;
        end
    end

    // R8: once locked, a write leaves the configuration untouched
    assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (locked && wr) |=> $stable(cfg));

    // R8: the lock is held until reset
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int LONG_EXP  = 18,
    parameter int SHORT_EXP = 13,
    parameter int OFF_EXP   = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  wdog_cfg_t cfg,
    input  logic      restart,
    output logic      expire
);
    localparam int CW = LONG_EXP;
    localparam logic [CW-1:0] PRELOAD    = CW'(1) << OFF_EXP;
    localparam logic [CW-1:0] LONG_MASK  = {CW{1'b1}};
    localparam logic [CW-1:0] SHORT_MASK = (CW'(1) << SHORT_EXP) - CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] term_mask;
    logic          at_term;
    wdog_act_t     act;

    // Terminal decode: selected low bits all ones. Count runs PRELOAD..mask,
    // plus the expiry edge, giving 2^n - 2^OFF_EXP cycles.
    assign term_mask = cfg.short_rate ? SHORT_MASK : LONG_MASK;
    assign at_term   = (cnt & term_mask) == term_mask;

    always_comb act = wdog_pick(cfg.halt, restart, at_term);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= PRELOAD;
            expire <= 1'b0;
        end else begin
            unique case (act)
                ACT_HOLD, ACT_RESTART: begin
                    cnt    <= PRELOAD;
                    expire <= 1'b0;
                end
                ACT_EXPIRE: begin
                    cnt    <= PRELOAD;
                    expire <= 1'b1;
                end
                default: begin
                    cnt    <= cnt + CW'(1);
                    expire <= 1'b0;
                end
            endcase
        end
    end

    // R5: a request lasts exactly one cycle
    assert_req_single_R5: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    // R4: while disabled no request follows
    assert_halt_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        cfg.halt |=> !expire);

    // R10: a restart sampled at any edge, terminal included, suppresses the request
    assert_restart_wins_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> !expire);

endmodule

// File: rtl/wdog_cause.sv
module wdog_cause (
    input  logic clk,
    input  logic por_rst,
    input  logic expire,
    output logic cause
);
    always_ff @(posedge clk) begin
        if (por_rst) cause <= 1'b0;
        else if (expire) cause <= 1'b1;
    end

    // R6: a request sets the flag in the next cycle
    assert_cause_set_R6: assert property (@(posedge clk) disable iff (por_rst)
        expire |=> cause);

    // R7: only power-on reset clears the flag
    assert_cause_sticky_R7: assert property (@(posedge clk) disable iff (por_rst)
        cause |=> cause);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int LONG_EXP  = 18,
    parameter int SHORT_EXP = 13,
    parameter int OFF_EXP   = 4
) (
    input  logic clk,
    input  logic por_rst,
    input  logic sys_rst,
    input  logic cfg_wr,
    input  logic cfg_short,
    input  logic cfg_halt,
    input  logic kick,
    output logic wdt_rst_req,
    output logic wdt_cause
);
    logic      rst_any;
    wdog_cfg_t wr_data;
    wdog_cfg_t cfg;
    logic      cfg_load;
    logic      restart;

    assign rst_any = por_rst || sys_rst;
    assign wr_data = '{short_rate: cfg_short, halt: cfg_halt};
    assign restart = kick || cfg_load;

    wdog_cfg_lock u_cfg (
        .clk      (clk),
        .rst      (rst_any),
        .wr       (cfg_wr),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .cfg_load (cfg_load)
    );

    wdog_count #(
        .LONG_EXP  (LONG_EXP),
        .SHORT_EXP (SHORT_EXP),
        .OFF_EXP   (OFF_EXP)
    ) u_count (
        .clk     (clk),
        .rst     (rst_any),
        .cfg     (cfg),
        .restart (restart),
        .expire  (wdt_rst_req)
    );

    wdog_cause u_cause (
        .clk     (clk),
        .por_rst (por_rst),
        .expire  (wdt_rst_req),
        .cause   (wdt_cause)
    );

    // R3: the cycle after any reset carries no request
    assert_reset_quiet_R3: assert property (@(posedge clk)
        rst_any |=> !wdt_rst_req);

endmodule

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
    localparam int SE = 6, LE = 8, OE = 2;
    localparam int NS = (1 << SE) - (1 << OE);  // 60
    localparam int NL = (1 << LE) - (1 << OE);  // 252

    logic clk = 1'b0;
    logic por_rst = 1'b1, sys_rst = 1'b0;
    logic cfg_wr = 1'b0, cfg_short = 1'b0, cfg_halt = 1'b0, kick = 1'b0;
    logic wdt_rst_req, wdt_cause;
    int   tests = 0, fails = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    wdog_timer #(.LONG_EXP(LE), .SHORT_EXP(SE), .OFF_EXP(OE)) u_wdog_timer (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .cfg_wr(cfg_wr),
        .cfg_short(cfg_short), .cfg_halt(cfg_halt), .kick(kick),
        .wdt_rst_req(wdt_rst_req), .wdt_cause(wdt_cause));

    task automatic check(input string rq, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask
    task automatic pulse_por();
        por_rst = 1'b1; step(); por_rst = 1'b0;
    endtask
    task automatic pulse_sys();
        sys_rst = 1'b1; step(); sys_rst = 1'b0;
    endtask
    task automatic pulse_kick();
        kick = 1'b1; step(); kick = 1'b0;
    endtask
    task automatic write_cfg(input logic s, input logic h);
        cfg_wr = 1'b1; cfg_short = s; cfg_halt = h; step(); cfg_wr = 1'b0;
    endtask
    // Rising edges counted until the request is seen (limit if never).
    task automatic measure(output int n, input int limit);
        n = 0;
        while (n < limit) begin
            step(); n++;
            if (wdt_rst_req) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int bad;
        @(negedge clk);
        pulse_por();
        check("R3 reset req", int'(wdt_rst_req), 0);
        check("R7 reset cause", int'(wdt_cause), 0);

        // R2/R3: default long period after reset
        measure(n, 3 * NL);
        check("R2 long period after reset", n, NL);

        // R1/R11: short period measured from the accepted write
        pulse_por();
        write_cfg(1'b1, 1'b0);
        measure(n, 3 * NL);
        check("R1 R11 short period", n, NS);
        step();
        check("R5 one-cycle req", int'(wdt_rst_req), 0);
        check("R6 cause set", int'(wdt_cause), 1);
        measure(n, 3 * NL);
        check("R5 periodic restart", n, NS - 1);

        // R7/R3: system reset keeps cause, clears config
        pulse_sys();
        check("R7 cause kept over sys reset", int'(wdt_cause), 1);
        measure(n, 3 * NL);
        check("R3 long after sys reset", n, NL);
        pulse_por();
        check("R7 por clears cause", int'(wdt_cause), 0);

        // R8: second write ignored and does not restart (first write edge E0, second E1)
        write_cfg(1'b1, 1'b0);
        write_cfg(1'b0, 1'b1);
        measure(n, 3 * NL);
        check("R8 second write ignored", n, NS - 1);

        // R4: disabled watchdog stays quiet, kick included
        pulse_por();
        write_cfg(1'b1, 1'b1);
        bad = 0;
        for (int i = 0; i < 3 * NL; i++) begin
            if (i == NS) pulse_kick(); else step();
            if (wdt_rst_req) bad++;
        end
        check("R4 disabled no req", bad, 0);
        check("R4 disabled cause", int'(wdt_cause), 0);
        write_cfg(1'b0, 1'b0);
        measure(n, 4 * NL);
        check("R8 R4 write after lock ignored", n, 4 * NL);

        // R9/R10: kick sweep over every offset within the short period
        pulse_por();
        write_cfg(1'b1, 1'b0);
        for (int d = 0; d < NS; d++) begin
            pulse_kick();
            bad = 0;
            for (int i = 0; i < d; i++) begin
                step();
                if (wdt_rst_req) bad++;
            end
            pulse_kick();
            if (wdt_rst_req) bad++;
            check("R10 no req before kick restart", bad, 0);
            measure(n, 3 * NL);
            check("R9 period after kick", n, NS);
            step();
        end

        // R10: kick on the terminal edge in long mode
        pulse_por();
        repeat (NL - 1) step();
        pulse_kick();
        check("R10 long terminal kick", int'(wdt_rst_req), 0);
        measure(n, 3 * NL);
        check("R9 long period after kick", n, NL);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule